// File: doc/BRIEF.md
# Effective Address Unit

This block works out the memory address for a single operand access. Each request names an addressing mode, carries the address field of the instruction, and presents the current contents of the selected pointer register and of the index register, along with the active segment value. One cycle after the request strobe the block presents a 20-bit physical address with a valid pulse. It is a purely combinational address path with one output register stage, so a sequencer can issue a request on any cycle.

Eight modes are supported. Direct-full takes the 20-bit field as it stands. Reduced direct takes the low 16 bits of the field as an offset. Register indirect uses the pointer contents as the offset. Four auto-modify modes add or subtract the access size from the pointer, either before or after it is used. Indexed mode adds the index contents to the low 16 bits of the field. Every offset-based mode can be relocated by a segment: the segment is multiplied by 16 and added to the offset. When an auto-modify mode is used, the updated pointer goes back to the external register file on a write-back port in the same cycle as the valid pulse.

Top module: `addr_gen_unit`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, `addr_valid`, `wb_en`, `wb_sel`, `wb_data` and `phys_addr` are all zero.
- R2: `addr_valid` is high in exactly the cycle after a cycle with `req` high. Without a request, `phys_addr` holds its last value.
- R3: Mode 3'd0 (direct full) gives `phys_addr` = `addr_field`. `seg_en` and `seg_val` have no effect in this mode.
- R4: In every mode other than 3'd0, let off be the 16-bit offset. With `seg_en`=1, `phys_addr` = (`seg_val`*16 + off) mod 2^20. With `seg_en`=0, `phys_addr` = off zero-extended.
- R5: Mode 3'd1 (reduced direct) uses off = `addr_field[15:0]`. Bits 19:16 of the field are ignored.
- R6: Mode 3'd2 (register indirect) uses off = `ptr_val` and raises no write-back.
- R7: Modes 3'd3 (pre-increment) and 3'd4 (pre-decrement) use off = (`ptr_val` ± step) mod 2^16, and write back that same value.
- R8: Modes 3'd5 (post-increment) and 3'd6 (post-decrement) use off = `ptr_val`, and write back (`ptr_val` ± step) mod 2^16.
- R9: The step is 1 when `step_word`=0 and 2 when `step_word`=1.
- R10: Mode 3'd7 (indexed) uses off = (`addr_field[15:0]` + `idx_val`) mod 2^16 and raises no write-back.
- R11: `wb_en` is high only together with `addr_valid`, and only for modes 3'd3 to 3'd6. `wb_sel` equals the `ptr_sel` of that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request strobe, one access per high cycle |
| mode | input | 3 | Addressing mode select |
| seg_en | input | 1 | Relocate the offset by the segment |
| step_word | input | 1 | Access size: 0 = byte, 1 = word |
| addr_field | input | 20 | Address field taken from the instruction |
| ptr_sel | input | 2 | Pointer register number |
| ptr_val | input | 16 | Contents of the selected pointer register |
| idx_val | input | 16 | Contents of the index register |
| seg_val | input | 16 | Current segment value |
| addr_valid | output | 1 | Address ready, one cycle after `req` |
| phys_addr | output | 20 | Physical address |
| wb_en | output | 1 | Pointer write-back strobe |
| wb_sel | output | 2 | Pointer register to update |
| wb_data | output | 16 | Updated pointer value |

## Verification
The assertions assume that all request inputs are stable and known in any cycle where `req` is high, and that `mode` is one of the eight codes. They make no assumption about `ptr_val` tracking the write-back, because the register file is outside the block. The bench drives inputs only at falling edges and pulses `req` for one cycle. It then holds a quiet cycle, so that each result and the hold behaviour are seen separately. It sweeps every mode, both segment settings and both step sizes, over operand values placed at the 16-bit and 20-bit wrap points.

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int NPTR = 4,
  parameter int OW   = 16,
  parameter int PAW  = 20,
  localparam int SW  = (NPTR > 1) ? $clog2(NPTR) : 1,
  localparam int SHF = PAW - OW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic [2:0]     mode,
  input  logic           seg_en,
  input  logic           step_word,
  input  logic [PAW-1:0] addr_field,
  input  logic [SW-1:0]  ptr_sel,
  input  logic [OW-1:0]  ptr_val,
  input  logic [OW-1:0]  idx_val,
  input  logic [OW-1:0]  seg_val,
  output logic           addr_valid,
  output logic [PAW-1:0] phys_addr,
  output logic           wb_en,
  output logic [SW-1:0]  wb_sel,
  output logic [OW-1:0]  wb_data
);

  localparam logic [2:0] M_FULL  = 3'd0;
  localparam logic [2:0] M_RDIR  = 3'd1;
  localparam logic [2:0] M_IND   = 3'd2;
  localparam logic [2:0] M_PREI  = 3'd3;
  localparam logic [2:0] M_PRED  = 3'd4;
  localparam logic [2:0] M_POSTI = 3'd5;
  localparam logic [2:0] M_POSTD = 3'd6;
  localparam logic [2:0] M_IDX   = 3'd7;

  logic [OW-1:0]  step, ptr_inc, ptr_dec, ptr_new, offset;
  logic [PAW-1:0] seg_base, reloc, next_addr;
  logic           automod;

  assign step    = step_word ? OW'(2) : OW'(1);
  assign ptr_inc = ptr_val + step;
  assign ptr_dec = ptr_val - step;
  assign automod = (mode >= M_PREI) && (mode <= M_POSTD);
  assign ptr_new = (mode == M_PREI || mode == M_POSTI) ? ptr_inc : ptr_dec;

  always_comb begin
    unique case (mode)
      M_RDIR:  offset = addr_field[OW-1:0];
      M_IND:   offset = ptr_val;
      M_PREI:  offset = ptr_inc;
      M_PRED:  offset = ptr_dec;
      M_POSTI: offset = ptr_val;
      M_POSTD: offset = ptr_val;
      M_IDX:   offset = addr_field[OW-1:0] + idx_val;
      default: offset = '0;
    endcase
  end

  assign seg_base  = seg_en ? {seg_val, {SHF{1'b0}}} : '0;
  assign reloc     = seg_base + {{SHF{1'b0}}, offset};
  assign next_addr = (mode == M_FULL) ? addr_field : reloc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      phys_addr  <= '0;
      wb_en      <= 1'b0;
      wb_sel     <= '0;
      wb_data    <= '0;
    end else begin
      addr_valid <= req;
      wb_en      <= req && automod;
      if (req) begin
        phys_addr <= next_addr;
        wb_sel    <= ptr_sel;
        wb_data   <= ptr_new;
      end
    end
  end

endmodule

module addr_gen_unit_chk #(
  parameter int NPTR = 4,
  parameter int OW   = 16,
  parameter int PAW  = 20,
  localparam int SW  = (NPTR > 1) ? $clog2(NPTR) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req,
  input logic [2:0]     mode,
  input logic           seg_en,
  input logic           step_word,
  input logic [PAW-1:0] addr_field,
  input logic [SW-1:0]  ptr_sel,
  input logic [OW-1:0]  ptr_val,
  input logic           addr_valid,
  input logic [PAW-1:0] phys_addr,
  input logic           wb_en,
  input logic [SW-1:0]  wb_sel,
  input logic [OW-1:0]  wb_data
);

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> addr_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !addr_valid && $stable(phys_addr)); // R2
  AST_FULL_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode == 3'd0 |=> phys_addr == $past(addr_field)); // R3
  AST_WB_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> addr_valid); // R11
  AST_WB_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> wb_en == ($past(mode) >= 3'd3 && $past(mode) <= 3'd6)); // R11
  AST_WB_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode >= 3'd3 && mode <= 3'd6 |=> wb_sel == $past(ptr_sel)); // R11
  AST_PRE_USES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    req && !seg_en && (mode == 3'd3 || mode == 3'd4) |=> phys_addr == PAW'(wb_data)); // R7
  AST_POST_USES_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    req && !seg_en && (mode == 3'd5 || mode == 3'd6) |=> phys_addr == PAW'($past(ptr_val))); // R8
  AST_POST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    req && mode == 3'd5 |=> wb_data == OW'($past(ptr_val) + ($past(step_word) ? 2 : 1))); // R9

endmodule

bind addr_gen_unit addr_gen_unit_chk #(.NPTR(NPTR), .OW(OW), .PAW(PAW)) i_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .seg_en(seg_en),
  .step_word(step_word), .addr_field(addr_field), .ptr_sel(ptr_sel),
  .ptr_val(ptr_val), .addr_valid(addr_valid), .phys_addr(phys_addr),
  .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data)
);

// File: tb/test_addr_gen_unit.sv
module test_addr_gen_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [2:0]  mode = '0;
  logic        seg_en = 1'b0;
  logic        step_word = 1'b0;
  logic [19:0] addr_field = '0;
  logic [1:0]  ptr_sel = '0;
  logic [15:0] ptr_val = '0, idx_val = '0, seg_val = '0;
  logic        addr_valid, wb_en;
  logic [19:0] phys_addr;
  logic [1:0]  wb_sel;
  logic [15:0] wb_data;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_gen_unit i_addr_gen_unit (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .seg_en(seg_en),
    .step_word(step_word), .addr_field(addr_field), .ptr_sel(ptr_sel),
    .ptr_val(ptr_val), .idx_val(idx_val), .seg_val(seg_val),
    .addr_valid(addr_valid), .phys_addr(phys_addr), .wb_en(wb_en),
    .wb_sel(wb_sel), .wb_data(wb_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mtag(input int m);
    case (m)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      3, 4: return "R7";
      5, 6: return "R8";
      default: return "R10";
    endcase
  endfunction

  logic [15:0] ptrs [6] = '{16'h0000, 16'h0001, 16'hFFFF, 16'hFFFE, 16'h1234, 16'h8000};
  logic [15:0] segs [4] = '{16'h0000, 16'hFFFF, 16'hF000, 16'h1234};
  logic [19:0] flds [3] = '{20'hFFFFF, 20'h0ABCD, 20'h1FFFF};

  initial begin
    repeat (3) @(negedge clk);
    chk(!addr_valid && !wb_en && phys_addr == 0 && wb_sel == 0 && wb_data == 0, "R1 reset state",
        {addr_valid, wb_en, phys_addr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!addr_valid && !wb_en && phys_addr == 0, "R1 after reset", {addr_valid, phys_addr}, 0);

    for (int m = 0; m < 8; m++)
      for (int se = 0; se < 2; se++)
        for (int sw = 0; sw < 2; sw++)
          for (int p = 0; p < 6; p++)
            for (int s = 0; s < 4; s++)
              for (int f = 0; f < 3; f++) begin
                logic [15:0] step, np, off;
                logic [19:0] expa;
                bit am;
                mode = 3'(m); seg_en = se[0]; step_word = sw[0];
                ptr_val = ptrs[p]; seg_val = segs[s]; addr_field = flds[f];
                idx_val = (f == 1) ? 16'h0001 : 16'hFFFF;
                ptr_sel = 2'((p + s) % 4);
                step = sw ? 16'd2 : 16'd1;
                np = (m == 3 || m == 5) ? ptr_val + step : ptr_val - step;
                case (m)
                  1: off = addr_field[15:0];
                  3, 4: off = np;
                  7: off = addr_field[15:0] + idx_val;
                  default: off = ptr_val;
                endcase
                expa = (m == 0) ? addr_field
                     : (se ? 20'((32'(seg_val) * 16 + 32'(off)) % 32'h100000) : {4'h0, off});
                am = (m >= 3 && m <= 6);
                req = 1'b1;
                @(negedge clk);
                req = 1'b0;
                chk(addr_valid, "R2 valid after req", 32'(addr_valid), 1);
                chk(phys_addr == expa, {mtag(m), se ? " R4 seg" : " R4 flat", sw ? " R9 word" : " R9 byte"},
                    32'(phys_addr), 32'(expa));
                chk(wb_en == am, "R11 wb_en mode", 32'(wb_en), 32'(am));
                if (am) begin
                  chk(wb_data == np, {mtag(m), " R9 write-back"}, 32'(wb_data), 32'(np));
                  chk(wb_sel == 2'((p + s) % 4), "R11 wb_sel", 32'(wb_sel), 32'((p + s) % 4));
                end
                mode = 3'(7 - m); addr_field = ~addr_field; ptr_val = ~ptr_val;
                @(negedge clk);
                chk(!addr_valid && !wb_en, "R2 no valid without req", {addr_valid, wb_en}, 0);
                chk(phys_addr == expa, "R2 hold without req", 32'(phys_addr), 32'(expa));
              end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule